// File: doc/BRIEF.md
# Page-Table-Entry Translation Cache with Miss Walker

This block translates virtual addresses into physical addresses for the process that is running. It keeps a direct-mapped array of page table entries indexed by the low bits of the virtual page number. A request whose page is resident is answered one cycle after it is accepted, with no memory traffic. A miss starts a fixed walk over a single-outstanding read port. The first read fetches a page-table pointer from the process table. The second read fetches the page table entry. The entry is installed and the translation is returned. Only then may the requester perform its real memory reference, so a miss costs several memory cycles.

A fetched entry whose valid bit is clear is not installed and is answered with a page-fail flag. An invalidate-all input drops every resident entry in one cycle, for use on a process switch. A walk that is in flight when the invalidate arrives still answers its requester, but it leaves nothing behind in the array.

Top module: `pte_xlat_cache`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` and `mem_rd_valid` are 0, and every entry is empty, so the first lookup of any page misses.
- R2: A request accepted in cycle N whose page is resident gets `rsp_valid` in cycle N+1, with `rsp_paddr` = {stored physical page, request offset}, `rsp_fault` 0 and no memory read.
- R3: A miss issues exactly two reads, in order. The first is at `upt_base` + VPN[12:9]. The second is at (first read data[21:0]) + VPN[8:0]. The response comes only in the cycle after the second read's data returns, which is 5 cycles after acceptance with a memory that is always ready and has a one-cycle delay.
- R4: Read data bit 13 is the entry's valid flag and bits 12:0 are the physical page. A valid entry is installed, so the next request to the same page hits. The 9 offset bits pass through unchanged.
- R5: Each page can live only in the entry selected by VPN[8:0]. A page with the same index but a different tag VPN[12:9] replaces it.
- R6: An entry with bit 13 clear returns `rsp_fault` 1 with `rsp_paddr` 0 and is not installed, so a repeat request walks again.
- R7: A one-cycle `inv_all` pulse empties every entry. Later lookups of pages that were resident miss.
- R8: If `inv_all` is raised during a walk, the walk still returns its translation but does not install it.
- R9: While a walk is in progress `req_ready` is 0, and at most one read is outstanding.
- R10: `mem_rd_valid` stays high with `mem_rd_addr` unchanged until `mem_rd_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_all | input | 1 | Empty all entries |
| upt_base | input | 22 | Physical base address of the process table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_vaddr | input | 22 | Virtual address: page number 21:9, offset 8:0 |
| rsp_valid | output | 1 | Translation result valid for one cycle |
| rsp_paddr | output | 22 | Physical address: page 21:9, offset 8:0 |
| rsp_fault | output | 1 | Page-fail: fetched entry was not valid |
| mem_rd_valid | output | 1 | Walk read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 22 | Walk read address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Read data |

## Verification
A sequence of pages drives the translation path. It includes a repeat of the same page, two pages that share an index but differ in tag, both extreme indices and tags, and a page whose fetched entry is marked invalid. Each case is told apart by its result, its latency and its memory read count. The read addresses are compared with the process-table and page-table arithmetic. Directed runs pulse the invalidate while idle and in the middle of a walk, then show whether the entries survived. A slow memory exercises the read handshake hold.

// File: rtl/xc_pkg.sv
package xc_pkg;
  typedef enum logic [2:0] {
    WK_IDLE,
    WK_PTR_REQ,
    WK_PTR_WAIT,
    WK_PTE_REQ,
    WK_PTE_WAIT
  } wk_state_e;
endpackage

// File: rtl/xc_tag_array.sv
// Direct-mapped storage: one valid bit per entry plus tag and physical page.
module xc_tag_array #(
  parameter int IDX_W = 9,
  parameter int TAG_W = 4,
  parameter int PPN_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv_all,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_valid,
  output logic [TAG_W-1:0] lk_tag,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PPN_W-1:0] wr_ppn
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int ENT_W   = TAG_W + PPN_W;

  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] valid_d;
  logic [ENT_W-1:0]   ent_mem [ENTRIES];

  // Per-entry valid next state: invalidate dominates a same-cycle install.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_valid
    always_comb begin
      if (inv_all) begin
        valid_d[g] = 1'b0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        valid_d[g] = 1'b1;
      end else begin
        valid_d[g] = valid_q[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_d;
    end
  end

  // Payload storage carries no reset; validity is held separately.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_mem[wr_idx] <= {wr_tag, wr_ppn};
    end
  end

  always_comb begin
    lk_valid = valid_q[lk_idx];
    {lk_tag, lk_ppn} = ent_mem[lk_idx];
  end
endmodule

// File: rtl/xc_walker.sv
// Lookup decision and two-read miss walk.
module xc_walker
  import xc_pkg::*;
#(
  parameter int VPN_W  = 13,
  parameter int IDX_W  = 9,
  parameter int PPN_W  = 13,
  parameter int OFF_W  = 9,
  parameter int DATA_W = 32,
  localparam int TAG_W = VPN_W - IDX_W,
  localparam int VA_W  = VPN_W + OFF_W,
  localparam int PA_W  = PPN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_all,
  input  logic [PA_W-1:0]   upt_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_fault,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [PA_W-1:0]   mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic [IDX_W-1:0]  lk_idx,
  input  logic              lk_valid,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [PPN_W-1:0]  lk_ppn,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [PPN_W-1:0]  wr_ppn
);
  wk_state_e         state_q, state_d;
  logic [VPN_W-1:0]  vpn_q, vpn_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic [PA_W-1:0]   ptbase_q, ptbase_d;
  logic              kill_q, kill_d;
  logic              rsp_valid_q, rsp_valid_d;
  logic              rsp_fault_q, rsp_fault_d;
  logic [PA_W-1:0]   rsp_paddr_q, rsp_paddr_d;
  logic              rsp_load;

  logic [VPN_W-1:0]  req_vpn;
  logic [OFF_W-1:0]  req_off;
  logic              hit;
  logic              pte_ok;
  logic [PPN_W-1:0]  pte_ppn;
  logic [DATA_W-PA_W-1:0] unused_data_hi;

  assign req_vpn        = req_vaddr[VA_W-1:OFF_W];
  assign req_off        = req_vaddr[OFF_W-1:0];
  assign lk_idx         = req_vpn[IDX_W-1:0];
  assign hit            = lk_valid && (lk_tag == req_vpn[VPN_W-1:IDX_W]);
  assign pte_ok         = mem_rsp_data[PPN_W];
  assign pte_ppn        = mem_rsp_data[PPN_W-1:0];
  assign unused_data_hi = mem_rsp_data[DATA_W-1:PA_W];

  assign wr_idx = vpn_q[IDX_W-1:0];
  assign wr_tag = vpn_q[VPN_W-1:IDX_W];
  assign wr_ppn = pte_ppn;

  // Next-state logic
  always_comb begin
    state_d      = state_q;
    vpn_d        = vpn_q;
    off_d        = off_q;
    ptbase_d     = ptbase_q;
    kill_d       = kill_q;
    rsp_valid_d  = 1'b0;
    rsp_fault_d  = 1'b0;
    rsp_paddr_d  = rsp_paddr_q;
    rsp_load     = 1'b0;
    req_ready    = 1'b0;
    mem_rd_valid = 1'b0;
    mem_rd_addr  = '0;
    wr_en        = 1'b0;

    if (state_q != WK_IDLE && inv_all) begin
      kill_d = 1'b1;
    end

    unique case (state_q)
      WK_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          if (hit) begin
            rsp_valid_d = 1'b1;
            rsp_load    = 1'b1;
            rsp_paddr_d = {lk_ppn, req_off};
          end else begin
            vpn_d   = req_vpn;
            off_d   = req_off;
            kill_d  = 1'b0;
            state_d = WK_PTR_REQ;
          end
        end
      end
      WK_PTR_REQ: begin
        mem_rd_valid = 1'b1;
        mem_rd_addr  = upt_base + PA_W'(vpn_q[VPN_W-1:IDX_W]);
        if (mem_rd_ready) begin
          state_d = WK_PTR_WAIT;
        end
      end
      WK_PTR_WAIT: begin
        if (mem_rsp_valid) begin
          ptbase_d = mem_rsp_data[PA_W-1:0];
          state_d  = WK_PTE_REQ;
        end
      end
      WK_PTE_REQ: begin
        mem_rd_valid = 1'b1;
        mem_rd_addr  = ptbase_q + PA_W'(vpn_q[IDX_W-1:0]);
        if (mem_rd_ready) begin
          state_d = WK_PTE_WAIT;
        end
      end
      WK_PTE_WAIT: begin
        if (mem_rsp_valid) begin
          wr_en       = pte_ok && !kill_q && !inv_all;
          rsp_valid_d = 1'b1;
          rsp_load    = 1'b1;
          rsp_fault_d = !pte_ok;
          rsp_paddr_d = pte_ok ? {pte_ppn, off_q} : '0;
          state_d     = WK_IDLE;
        end
      end
      default: state_d = WK_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= WK_IDLE;
      kill_q      <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      kill_q      <= kill_d;
      rsp_valid_q <= rsp_valid_d;
      rsp_fault_q <= rsp_fault_d;
    end
  end

  // Datapath registers with explicit enables
  always_ff @(posedge clk) begin
    if (state_q == WK_IDLE) begin
      vpn_q <= vpn_d;
      off_q <= off_d;
    end
    if (state_q == WK_PTR_WAIT) begin
      ptbase_q <= ptbase_d;
    end
    if (rsp_load) begin
      rsp_paddr_q <= rsp_paddr_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_fault = rsp_fault_q;
  assign rsp_paddr = rsp_paddr_q;
endmodule

// File: rtl/pte_xlat_cache.sv
module pte_xlat_cache #(
  parameter int VPN_W  = 13,
  parameter int IDX_W  = 9,
  parameter int PPN_W  = 13,
  parameter int OFF_W  = 9,
  parameter int DATA_W = 32,
  localparam int TAG_W = VPN_W - IDX_W,
  localparam int VA_W  = VPN_W + OFF_W,
  localparam int PA_W  = PPN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_all,
  input  logic [PA_W-1:0]   upt_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_fault,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [PA_W-1:0]   mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  logic [IDX_W-1:0] lk_idx;
  logic             lk_valid;
  logic [TAG_W-1:0] lk_tag;
  logic [PPN_W-1:0] lk_ppn;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [TAG_W-1:0] wr_tag;
  logic [PPN_W-1:0] wr_ppn;

  xc_tag_array #(
    .IDX_W(IDX_W), .TAG_W(TAG_W), .PPN_W(PPN_W)
  ) array_i (
    .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
    .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_ppn(lk_ppn),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_ppn(wr_ppn)
  );

  xc_walker #(
    .VPN_W(VPN_W), .IDX_W(IDX_W), .PPN_W(PPN_W), .OFF_W(OFF_W), .DATA_W(DATA_W)
  ) walker_i (
    .clk(clk), .rst_n(rst_n), .inv_all(inv_all), .upt_base(upt_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_ppn(lk_ppn),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_ppn(wr_ppn)
  );
endmodule

// File: rtl/pte_xlat_cache_chk.sv
module pte_xlat_cache_chk #(
  parameter int PA_W = 22
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_fault,
  input logic            mem_rd_valid,
  input logic            mem_rd_ready,
  input logic [PA_W-1:0] mem_rd_addr,
  input logic            mem_rsp_valid
);
  // R9: no new request is taken while a walk read is being issued
  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !req_ready);

  // R10: a pending read holds its request and address
  p_rdhold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  // R2 / R3: an accepted request either answers next cycle or starts a walk
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_valid || mem_rd_valid));

  // R3: a response not caused by a hit follows returned read data
  p_walk_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !$past(req_valid && req_ready)) |-> $past(mem_rsp_valid));

  // R6: a page-fail response carries a zero address
  p_fault_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));
endmodule

bind pte_xlat_cache pte_xlat_cache_chk #(.PA_W(PA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
  .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
  .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/pte_xlat_cache_tb_top.sv
`timescale 1ns/1ps
module pte_xlat_cache_tb_top;
  localparam logic [21:0] UPT_BASE = 22'h000100;
  localparam logic [21:0] PT_BASE  = 22'h010000;
  localparam logic [12:0] BAD_VPN  = 13'h00AB;
  localparam int WD_LIMIT = 20000;

  // {vpn, offset, expected read count, expected fault}
  localparam logic [24:0] VEC [10] = '{
    {13'h0005, 9'h012, 2'd2, 1'b0},  // R1 cold miss, R3, R4
    {13'h0005, 9'h1FF, 2'd0, 1'b0},  // R2 hit, R4 offset
    {13'h0205, 9'h0AA, 2'd2, 1'b0},  // R5 same index, other tag
    {13'h0005, 9'h001, 2'd2, 1'b0},  // R5 evicted
    {13'h01FF, 9'h100, 2'd2, 1'b0},  // top index
    {13'h1FFF, 9'h000, 2'd2, 1'b0},  // R5 top index, top tag
    {13'h1FFF, 9'h1FF, 2'd0, 1'b0},  // R2 hit
    {13'h00AB, 9'h055, 2'd2, 1'b1},  // R6 fault
    {13'h00AB, 9'h055, 2'd2, 1'b1},  // R6 not installed
    {13'h0005, 9'h0C3, 2'd0, 1'b0}   // R2 still resident
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        inv_all;
  logic        req_valid;
  logic        req_ready;
  logic [21:0] req_vaddr;
  logic        rsp_valid;
  logic [21:0] rsp_paddr;
  logic        rsp_fault;
  logic        mem_rd_valid;
  logic        mem_rd_ready;
  logic [21:0] mem_rd_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  int  n_checks = 0;
  int  n_errors = 0;
  int  cycles = 0;
  bit  finished = 0;
  int  rd_count = 0;
  logic [21:0] rd_last, rd_prev;
  bit  stall_en = 0;
  int  wait_cnt = 0;

  always #5 clk = ~clk;

  pte_xlat_cache dut_i (
    .clk(clk), .rst_n(rst_n), .inv_all(inv_all), .upt_base(UPT_BASE),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  // Memory model: table pointers below PT_BASE, entries above it.
  function automatic logic [31:0] mem_word(input logic [21:0] a);
    logic [21:0] p;
    if (a < PT_BASE) begin
      p = PT_BASE + ((a - UPT_BASE) << 9);
      return {10'd0, p};
    end
    p = (a[21:0] * 22'd7 + 22'd3);
    return {18'd0, (a - PT_BASE) != {9'd0, BAD_VPN}, p[12:0]};
  endfunction

  function automatic logic [12:0] exp_ppn(input logic [12:0] vpn);
    logic [21:0] p;
    p = ({9'd0, vpn} * 22'd7 + 22'd3);
    return p[12:0];
  endfunction

  assign mem_rd_ready = !stall_en || (wait_cnt >= 3);

  always @(posedge clk) begin
    if (mem_rd_valid && !mem_rd_ready) wait_cnt <= wait_cnt + 1;
    else wait_cnt <= 0;
    mem_rsp_valid <= 1'b0;
    if (mem_rd_valid && mem_rd_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem_word(mem_rd_addr);
      rd_count      <= rd_count + 1;
      rd_prev       <= rd_last;
      rd_last       <= mem_rd_addr;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xlat(input logic [12:0] vpn, input logic [8:0] off,
                      input int inv_cyc, output logic [21:0] pa,
                      output bit flt, output int nrd, output int lat,
                      output bit stall_bad);
    int rd0;
    rd0 = rd_count;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = {vpn, off};
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    stall_bad = 0;
    while (!rsp_valid && lat < 100) begin
      if (req_ready) stall_bad = 1;
      if (lat == inv_cyc) inv_all = 1'b1;
      @(negedge clk);
      inv_all = 1'b0;
      lat++;
    end
    pa  = rsp_paddr;
    flt = rsp_fault;
    nrd = rd_count - rd0;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WD_LIMIT && !finished) begin
      finished = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, WD_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [21:0] pa;
    bit flt, sb;
    int nrd, lat;
    rst_n = 1'b0;
    inv_all = 1'b0;
    req_valid = 1'b0;
    req_vaddr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready && !rsp_valid && !mem_rd_valid, "R1 reset outputs",
        {29'd0, req_ready, rsp_valid, mem_rd_valid}, 32'h4);

    for (int i = 0; i < 10; i++) begin
      logic [12:0] v;
      logic [8:0]  o;
      int er;
      bit ef;
      logic [21:0] ep;
      v  = VEC[i][24:12];
      o  = VEC[i][11:3];
      er = int'(VEC[i][2:1]);
      ef = VEC[i][0];
      ep = ef ? 22'd0 : {exp_ppn(v), o};
      xlat(v, o, 0, pa, flt, nrd, lat, sb);
      chk(pa == ep && flt == ef, "R4/R6 translation result", {9'd0, flt, pa}, {9'd0, ef, ep});
      chk(nrd == er, "R2/R3/R5 read count", nrd, er);
      chk(lat == ((er == 0) ? 1 : 5), "R2/R3 latency", lat, (er == 0) ? 1 : 5);
      chk(!sb, "R9 ready low during walk", sb, 0);
      if (er == 2) begin
        chk(rd_prev == UPT_BASE + {18'd0, v[12:9]}, "R3 pointer address", rd_prev,
            UPT_BASE + {18'd0, v[12:9]});
        chk(rd_last == PT_BASE + {9'd0, v}, "R3 entry address", rd_last, PT_BASE + {9'd0, v});
      end
    end

    // R7: invalidate while idle
    @(negedge clk);
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
    xlat(13'h0005, 9'h010, 0, pa, flt, nrd, lat, sb);
    chk(nrd == 2, "R7 resident page lost after invalidate", nrd, 2);
    chk(pa == {exp_ppn(13'h0005), 9'h010}, "R7 refill result", pa, {exp_ppn(13'h0005), 9'h010});
    xlat(13'h1FFF, 9'h001, 0, pa, flt, nrd, lat, sb);
    chk(nrd == 2, "R7 second page lost after invalidate", nrd, 2);

    // R8: invalidate during a walk
    xlat(13'h00F0, 9'h021, 2, pa, flt, nrd, lat, sb);
    chk(pa == {exp_ppn(13'h00F0), 9'h021} && !flt, "R8 killed walk still answers",
        pa, {exp_ppn(13'h00F0), 9'h021});
    xlat(13'h00F0, 9'h021, 0, pa, flt, nrd, lat, sb);
    chk(nrd == 2, "R8 killed walk not installed", nrd, 2);
    xlat(13'h00F0, 9'h022, 0, pa, flt, nrd, lat, sb);
    chk(nrd == 0, "R8 later walk installs", nrd, 0);

    // R10: slow memory
    stall_en = 1;
    xlat(13'h0333, 9'h1AB, 0, pa, flt, nrd, lat, sb);
    chk(pa == {exp_ppn(13'h0333), 9'h1AB} && nrd == 2, "R10 result with slow memory",
        pa, {exp_ppn(13'h0333), 9'h1AB});
    chk(lat > 5 && !sb, "R10/R9 walk waits for ready", lat, 6);
    stall_en = 0;

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule